// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits in front of the private peripherals of a multi-core cluster and sorts each access into an 8 KB window. It determines which peripheral group the access targets. There are five groups: the coherency control page, the per-core interrupt CPU interfaces, the per-core timers, the per-core watchdogs and the shared interrupt distributor. For each access the block reports which instance in the group is targeted and the byte offset inside that peripheral. Addresses that fall into holes of the map are flagged, and nothing is selected for them.

The per-core groups each provide one extra "own core" page ahead of the explicit per-core pages. An access to that alias is redirected to the requester's own instance, using the core ID that comes with the request, so the index reported downstream is always a real core number. The address decode is purely combinational. Its result is captured in one register stage that is qualified by the request strobe.

Top module: `ppwin_decode`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid`, `rsp_sel`, `rsp_err`, `rsp_idx` and `rsp_offset` are all zero until the first request has been registered.
- R2: A request sampled with `req_valid` high produces `rsp_valid` high on the next clock edge. A clock edge with `req_valid` low gives `rsp_valid`, `rsp_sel` and `rsp_err` all low.
- R3: Addresses 0x000–0x0FF select the coherency control page (`rsp_sel` bit 0). `rsp_idx` is 0 and `rsp_offset` is address bits [7:0].
- R4: Page k+1 (address 0x100 + k×0x100, for k = 0..NUM_CORES) selects a CPU interface (`rsp_sel` bit 1) with `rsp_offset` equal to address bits [7:0]. For k = 0, `rsp_idx` equals `req_core`. For k ≥ 1, `rsp_idx` equals k−1.
- R5: Page 6+p (address 0x600 + p×0x100, for p = 0..NUM_CORES) with byte offset 0x00–0x1F inside the page selects a timer (`rsp_sel` bit 2). `rsp_offset` is address bits [4:0], and the index rule is the same as in R4, with p in place of k.
- R6: Byte offsets 0x20–0x3F in the same pages select the watchdog (`rsp_sel` bit 3), with the same index and offset rules as R5.
- R7: Byte offsets 0x40–0xFF inside a timer page are unmapped.
- R8: CPU interface pages beyond k = NUM_CORES that lie below 0x600 are unmapped. Timer pages beyond p = NUM_CORES that lie below 0x1000 are also unmapped.
- R9: Addresses 0x1000–0x1FFF select the distributor (`rsp_sel` bit 4), with `rsp_idx` 0 and `rsp_offset` equal to address bits [11:0].
- R10: An access to an "own core" alias page (CPU interface k = 0, or timer/watchdog p = 0) from a `req_core` value of NUM_CORES or more is unmapped.
- R11: An unmapped access returns `rsp_err` = 1 with `rsp_sel`, `rsp_idx` and `rsp_offset` all zero.
- R12: A valid, mapped response has exactly one bit set in `rsp_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe |
| req_addr | input | 13 | Byte address inside the window |
| req_core | input | CORE_W | ID of the requesting core |
| rsp_valid | output | 1 | Registered access strobe |
| rsp_sel | output | 5 | One-hot group select: 0 control, 1 CPU interface, 2 timer, 3 watchdog, 4 distributor |
| rsp_idx | output | CORE_W | Resolved core index for per-core groups |
| rsp_offset | output | 12 | Byte offset inside the selected peripheral |
| rsp_err | output | 1 | Access hit an unmapped location |

## Verification
Directed vectors cover every page edge: the first and last byte of each group, the alias page under each core ID, the hole page between the last CPU interface and the first timer page, the timer page bytes above the watchdog, and the timer pages past the last core. These vectors separate off-by-one page limits and alias-versus-explicit indexing errors. Random addresses across the whole window, mixed with random core IDs that include out-of-range values and with idle cycles, find decode overlaps. They also check that nothing stale survives an idle or faulted cycle. The bench is run with three cores, so the core-ID range check and the hole page are both reachable.

// File: rtl/ppwin_pkg.sv
package ppwin_pkg;
   localparam int WIN_AW  = 13;
   localparam int OFF_W   = 12;
   localparam int NREG    = 5;
   localparam int RG_SCU   = 0;
   localparam int RG_CPUIF = 1;
   localparam int RG_TIMER = 2;
   localparam int RG_WDOG  = 3;
   localparam int RG_DIST  = 4;
   localparam int TMR_PAGE0 = 6;
   localparam int MAX_CORES = 4;
   typedef logic [NREG-1:0] region_t;
endpackage

// File: rtl/ppwin_page_map.sv
module ppwin_page_map
   import ppwin_pkg::*;
#(
   parameter int NUM_CORES = 4
) (
   input  logic [WIN_AW-1:0] addr,
   output region_t           region,
   output logic [3:0]        unit,
   output logic [OFF_W-1:0]  offset,
   output logic              hole
);
   localparam int CPUIF_HI = NUM_CORES + 1;
   localparam int TMR_HI   = TMR_PAGE0 + NUM_CORES;

   logic [3:0] page;
   assign page = addr[11:8];

   always_comb begin
      region = '0;
      unit   = '0;
      offset = '0;
      hole   = 1'b0;
      if (addr[12]) begin
         region[RG_DIST] = 1'b1;
         offset = addr[11:0];
      end else if (page == 4'd0) begin
         region[RG_SCU] = 1'b1;
         offset = {4'h0, addr[7:0]};
      end else if (page <= 4'(CPUIF_HI)) begin
         region[RG_CPUIF] = 1'b1;
         unit   = page - 4'd1;
         offset = {4'h0, addr[7:0]};
      end else if (page >= 4'(TMR_PAGE0) && page <= 4'(TMR_HI)) begin
         unit   = page - 4'(TMR_PAGE0);
         offset = {7'h0, addr[4:0]};
         case (addr[7:5])
            3'd0: region[RG_TIMER] = 1'b1;
            3'd1: region[RG_WDOG]  = 1'b1;
            default: begin
               hole   = 1'b1;
               unit   = '0;
               offset = '0;
            end
         endcase
      end else begin
         hole = 1'b1;
      end
   end

   // R8: every address is either exactly one group or a hole
   always_comb begin
      p_decode_total_r8: assert ($onehot(region) != hole)
         else $error("page map: region/hole mismatch");
   end
endmodule

// File: rtl/ppwin_unit_resolve.sv
module ppwin_unit_resolve #(
   parameter int NUM_CORES = 4,
   parameter int IDX_W     = 2
) (
   input  logic [3:0]       unit,
   input  logic             per_core,
   input  logic [IDX_W-1:0] core,
   output logic [IDX_W-1:0] idx,
   output logic             bad
);
   logic alias_hit;
   logic core_ok;

   assign alias_hit = per_core && (unit == 4'd0);

   generate
      if (NUM_CORES == (1 << IDX_W)) begin : g_full_range
         assign core_ok = 1'b1;
      end else begin : g_range_check
         assign core_ok = (core < IDX_W'(NUM_CORES));
      end
   endgenerate

   assign idx = alias_hit ? core : IDX_W'(unit - 4'd1);
   assign bad = alias_hit && !core_ok;

   // R4: a resolved per-core index always names an existing core
   always_comb begin
      p_idx_in_range_r4: assert (bad || !per_core || int'(idx) < NUM_CORES)
         else $error("resolve: index out of range");
   end
endmodule

// File: rtl/ppwin_decode.sv
module ppwin_decode
   import ppwin_pkg::*;
#(
   parameter int NUM_CORES = 4,
   localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [12:0]       req_addr,
   input  logic [CORE_W-1:0] req_core,
   output logic              rsp_valid,
   output logic [4:0]        rsp_sel,
   output logic [CORE_W-1:0] rsp_idx,
   output logic [11:0]       rsp_offset,
   output logic              rsp_err
);
   generate
      if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cfg
         $error("ppwin_decode: NUM_CORES must be 1..4 so CPU and timer pages stay apart");
      end
   endgenerate

   region_t            map_region;
   logic [3:0]         map_unit;
   logic [OFF_W-1:0]   map_offset;
   logic               map_hole;
   logic [CORE_W-1:0]  res_idx;
   logic               res_bad;
   logic               per_core;
   logic               fault;
   logic               take;

   ppwin_page_map #(.NUM_CORES(NUM_CORES)) u_map (
      .addr   (req_addr),
      .region (map_region),
      .unit   (map_unit),
      .offset (map_offset),
      .hole   (map_hole)
   );

   assign per_core = map_region[RG_CPUIF] | map_region[RG_TIMER] | map_region[RG_WDOG];

   ppwin_unit_resolve #(.NUM_CORES(NUM_CORES), .IDX_W(CORE_W)) u_res (
      .unit     (map_unit),
      .per_core (per_core),
      .core     (req_core),
      .idx      (res_idx),
      .bad      (res_bad)
   );

   assign fault = map_hole | res_bad;
   assign take  = req_valid & ~fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_sel    <= '0;
         rsp_idx    <= '0;
         rsp_offset <= '0;
         rsp_err    <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_sel    <= take ? map_region : '0;
         rsp_idx    <= (take && per_core) ? res_idx : '0;
         rsp_offset <= take ? map_offset : '0;
         rsp_err    <= req_valid & fault;
      end
   end

   // R2: response follows the strobe by one cycle
   p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R2: idle cycles leave nothing selected
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_sel == '0 && !rsp_err));
   // R12: mapped responses select exactly one group
   p_sel_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> ($countones(rsp_sel) == 1));
   // R11: faulted responses carry no selection data
   p_err_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_sel == '0 && rsp_idx == '0 && rsp_offset == '0));
   // R5: timer and watchdog offsets stay inside their 32-byte windows
   p_timer_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_sel[RG_TIMER] || rsp_sel[RG_WDOG]) |-> (rsp_offset < 12'h020));
endmodule

// File: tb/ppwin_decode_test.sv
module ppwin_decode_test;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 3;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [12:0]   req_addr = '0;
   logic [CW-1:0] req_core = '0;
   logic          rsp_valid;
   logic [4:0]    rsp_sel;
   logic [CW-1:0] rsp_idx;
   logic [11:0]   rsp_offset;
   logic          rsp_err;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ppwin_decode #(.NUM_CORES(NC)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_core(req_core), .rsp_valid(rsp_valid), .rsp_sel(rsp_sel),
      .rsp_idx(rsp_idx), .rsp_offset(rsp_offset), .rsp_err(rsp_err)
   );

   typedef struct packed {
      logic       v;
      logic [4:0] sel;
      logic [1:0] idx;
      logic [11:0] off;
      logic       err;
   } resp_t;

   string last_tag;

   function automatic resp_t model(input bit v, input int a, input int core);
      resp_t r;
      int k;
      int o;
      r = '0;
      r.v = v;
      last_tag = "R2";
      if (!v) return r;
      if (a >= 'h1000) begin
         r.sel = 5'b10000; r.off = 12'(a - 'h1000); last_tag = "R9";
      end else if (a < 'h100) begin
         r.sel = 5'b00001; r.off = 12'(a); last_tag = "R3";
      end else if (a < 'h100 * (NC + 2)) begin
         k = a / 256 - 1;
         last_tag = "R4";
         if (k == 0 && core >= NC) begin r.err = 1; last_tag = "R10"; end
         else begin
            r.sel = 5'b00010; r.off = 12'(a % 256);
            r.idx = 2'((k == 0) ? core : k - 1);
         end
      end else if (a >= 'h600 && a < 'h600 + (NC + 1) * 256) begin
         k = (a - 'h600) / 256;
         o = a % 256;
         if (o >= 'h40) begin r.err = 1; last_tag = "R7"; end
         else if (k == 0 && core >= NC) begin r.err = 1; last_tag = "R10"; end
         else begin
            r.sel = (o < 'h20) ? 5'b00100 : 5'b01000;
            last_tag = (o < 'h20) ? "R5" : "R6";
            r.off = 12'(o % 32);
            r.idx = 2'((k == 0) ? core : k - 1);
         end
      end else begin
         r.err = 1; last_tag = "R8";
      end
      return r;
   endfunction

   task automatic apply(input bit v, input int a, input int core);
      resp_t e;
      resp_t got;
      string tag;
      @(negedge clk);
      req_valid = v;
      req_addr  = 13'(a);
      req_core  = CW'(core);
      e = model(v, a, core);
      tag = last_tag;
      @(negedge clk);
      got = {rsp_valid, rsp_sel, rsp_idx, rsp_offset, rsp_err};
      n_vec++;
      if (got !== e) begin
         n_bad++;
         $display("FAIL %s (R11/R12 fields) addr=%h core=%0d v=%0b: got v=%0b sel=%b idx=%0d off=%h err=%0b, expected v=%0b sel=%b idx=%0d off=%h err=%0b",
                  tag, a, core, v, got.v, got.sel, got.idx, got.off, got.err,
                  e.v, e.sel, e.idx, e.off, e.err);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if ({rsp_valid, rsp_sel, rsp_idx, rsp_offset, rsp_err} !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: got %b expected 0", {rsp_valid, rsp_sel, rsp_idx, rsp_offset, rsp_err});
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if ({rsp_valid, rsp_sel, rsp_err} !== '0) begin
         n_bad++;
         $display("FAIL R1 after release: got %b expected 0", {rsp_valid, rsp_sel, rsp_err});
      end
      // R3 control page edges
      apply(1, 'h000, 0);
      apply(1, 'h0FF, 2);
      // R4 CPU interfaces, alias under each core ID
      for (int c = 0; c < NC; c++) apply(1, 'h104 + c, c);
      apply(1, 'h2A0, 1);
      apply(1, 'h4FF, 0);
      // R10 alias from out-of-range core
      apply(1, 'h100, 3);
      apply(1, 'h610, 3);
      apply(1, 'h630, 3);
      // R8 holes
      apply(1, 'h500, 0);
      apply(1, 'h5FF, 1);
      apply(1, 'hA00, 0);
      apply(1, 'hFFF, 2);
      // R5 / R6 timer and watchdog edges
      apply(1, 'h600, 2);
      apply(1, 'h61F, 1);
      apply(1, 'h620, 0);
      apply(1, 'h63F, 2);
      apply(1, 'h900, 0);
      apply(1, 'h93F, 0);
      // R7 bytes above the watchdog
      apply(1, 'h640, 0);
      apply(1, 'h7FF, 0);
      // R9 distributor edges
      apply(1, 'h1000, 1);
      apply(1, 'h1FFF, 0);
      // R2 idle after a mapped access, and after a fault
      apply(1, 'h1234, 0);
      apply(0, 'h1234, 0);
      apply(1, 'h500, 0);
      apply(0, 'h000, 0);
      // random mix
      for (int i = 0; i < 4000; i++) begin
         apply(($urandom % 8) != 0, int'($urandom_range(0, 8191)), int'($urandom_range(0, 3)));
      end
      finish_run();
   end
endmodule